// File: doc/BRIEF.md
# Banded Framebuffer SPI Display Streamer

This block takes 16-bit pixels from a stream that reads out a local colour buffer. It shifts each pixel to a serial display over a four-wire SPI link. The colour buffer is too small for a whole screen. The frame is therefore drawn as a series of horizontal bands, each a fixed number of lines deep. Each band is rendered and then streamed out before the next band is started. The streamer counts the pixels of every band and every band of a frame. It releases the display chip select after each band and flags band and frame completion with single-cycle pulses.

A select input gives every display pin to a host microcontroller. The host uses this to send the display's setup commands. While the host has the pins, the internal serializer is frozen: it takes no stream data, and a pixel that is part-way out stays where it stopped. When the host releases the pins, the serializer resumes that pixel where it stopped. Screen width, screen height, band depth and the SCK divider are build-time parameters. If the screen height is not a whole number of bands, the final band is shorter.

Top module: `band_spi_streamer`

## Requirements
- R1: After reset, chip select is high, SCK and MOSI are low, both done pulses are low, and stream ready is high.
- R2: Each accepted pixel is sent as 16 bits, most significant bit first. The pixel holds four 4-bit colour channels, with red in bits 15:12 and alpha in bits 3:0. MOSI changes only while SCK is low, and the display samples it on the rising edge of SCK.
- R3: The data/command line is high (data) on every SCK rising edge of a pixel transfer.
- R4: Chip select goes low when the first pixel of a band is accepted. It stays low through every gap between the pixels of that band.
- R5: A band holds SCREEN_W*BAND_LINES pixels. After the last bit of a band's final pixel, chip select goes high, and band_done is high for exactly one clock in that same cycle.
- R6: The last band of a frame holds the remaining SCREEN_H-(N-1)*BAND_LINES lines, where N is the number of bands. frame_done pulses in the same cycle as that band's band_done, and the next pixel starts the first band of a new frame.
- R7: Stream ready is low from the acceptance of a pixel until all 16 of its bits are sent. The next pixel is accepted only after that.
- R8: While the serializer is shifting, each high and each low phase of SCK lasts exactly CLK_DIV clock cycles.
- R9: While the host select is high, display SCK, MOSI, CS and DC equal the host's four signals in the same cycle.
- R10: While the host select is high, stream ready is low and no pixel is consumed. A pixel that is part-way out is frozen and then completes intact once the select drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 16 | Pixel from the colour buffer stream |
| s_tvalid | input | 1 | Pixel valid |
| s_tready | output | 1 | Streamer can take a pixel |
| host_sel | input | 1 | Hands all display pins to the host |
| host_sck | input | 1 | Host serial clock |
| host_mosi | input | 1 | Host serial data |
| host_cs_n | input | 1 | Host chip select, active low |
| host_dc | input | 1 | Host data/command select |
| disp_sck | output | 1 | Display serial clock |
| disp_mosi | output | 1 | Display serial data |
| disp_cs_n | output | 1 | Display chip select, active low |
| disp_dc | output | 1 | Display data/command select |
| band_done | output | 1 | One-cycle pulse after each band |
| frame_done | output | 1 | One-cycle pulse after the final band |

## Verification
The hardest case to reach is a host takeover while a pixel is only partly shifted out. The freeze has to keep the remaining bits intact, and no spurious SCK edge may appear at either switch. To reach it, the bench watches the number of bits received. It raises the select once five bits of a chosen pixel have gone out and SCK is low. It then sweeps all sixteen host pin patterns and offers a new pixel that must not be taken. The bench uses a 3x5 screen with 2-line bands, so the short final band of one line is crossed in every frame.

// File: rtl/band_spi_pkg.sv
package band_spi_pkg;

   localparam int PIX_BITS = 16;

   typedef struct packed {
      logic sck;
      logic mosi;
      logic cs_n;
      logic dc;
   } spi_pins_t;

   function automatic int div_up(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

endpackage

// File: rtl/pixel_shifter.sv
module pixel_shifter
   import band_spi_pkg::*;
#(
   parameter int PIX_W   = PIX_BITS,
   parameter int CLK_DIV = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [PIX_W-1:0] in_data,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             last_in_band,
   output logic             pix_fin,
   output spi_pins_t        pins
);

   localparam int BIT_CW = $clog2(PIX_W);
   localparam int PH_W   = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   initial begin
      assert (PIX_W >= 2) else $error("PIX_W must be at least 2");
      assert (CLK_DIV >= 1) else $error("CLK_DIV must be at least 1");
   end

   logic              busy;
   logic [PIX_W-1:0]  shreg;
   logic [BIT_CW-1:0] bit_cnt;
   logic              sck_q;
   logic              cs_n_q;
   logic              half_end;
   logic              step;

   assign step     = busy && en && half_end;
   assign in_ready = !busy && en;
   assign pix_fin  = step && sck_q && (bit_cnt == BIT_CW'(PIX_W - 1));

   generate
      if (CLK_DIV == 1) begin : g_nodiv
         assign half_end = 1'b1;
      end else begin : g_div
         logic [PH_W-1:0] phase;
         always_ff @(posedge clk) begin
            if (!rst_n || !busy) begin
               phase <= '0;
            end else if (en) begin
               phase <= half_end ? '0 : phase + 1'b1;
            end
         end
         assign half_end = (phase == PH_W'(CLK_DIV - 1));
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         shreg   <= '0;
         bit_cnt <= '0;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b1;
      end else if (in_valid && in_ready) begin
         busy    <= 1'b1;
         shreg   <= in_data;
         bit_cnt <= '0;
         sck_q   <= 1'b0;
         cs_n_q  <= 1'b0;
      end else if (step) begin
         sck_q <= ~sck_q;
         if (sck_q) begin
            if (pix_fin) begin
               busy  <= 1'b0;
               shreg <= '0;
               if (last_in_band) cs_n_q <= 1'b1;
            end else begin
               shreg   <= shreg << 1;
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   assign pins.sck  = sck_q;
   assign pins.mosi = shreg[PIX_W-1];
   assign pins.cs_n = cs_n_q;
   assign pins.dc   = 1'b1;

   assert_cs_low_on_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck_q) |-> !cs_n_q)
      else $error("SCK rose with chip select released");

   assert_freeze_on_host_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !en) |=> ($stable(shreg) && $stable(sck_q) && $stable(bit_cnt)))
      else $error("serializer moved while host owns the pins");

   assert_no_take_while_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !pix_fin) |=> (busy && $stable(bit_cnt) || $past(step)))
      else $error("pixel state changed without a shift step");

endmodule

// File: rtl/band_tracker.sv
module band_tracker #(
   parameter int SCREEN_W   = 240,
   parameter int SCREEN_H   = 320,
   parameter int BAND_LINES = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pix_fin,
   output logic last_in_band,
   output logic band_done,
   output logic frame_done
);

   localparam int NUM_BANDS  = band_spi_pkg::div_up(SCREEN_H, BAND_LINES);
   localparam int BAND_PIX   = SCREEN_W * BAND_LINES;
   localparam int TAIL_LINES = SCREEN_H - (NUM_BANDS - 1) * BAND_LINES;
   localparam int TAIL_PIX   = SCREEN_W * TAIL_LINES;
   localparam int PIX_CW     = $clog2(BAND_PIX + 1);
   localparam int BAND_CW    = $clog2(NUM_BANDS + 1);

   initial begin
      assert (SCREEN_W >= 1) else $error("SCREEN_W must be positive");
      assert (BAND_LINES >= 1) else $error("BAND_LINES must be positive");
      assert (BAND_LINES <= SCREEN_H) else $error("band deeper than screen");
   end

   logic [PIX_CW-1:0] pix_cnt;
   logic              final_band;
   logic              band_end;

   generate
      if (NUM_BANDS == 1) begin : g_single
         assign final_band = 1'b1;
      end else begin : g_multi
         logic [BAND_CW-1:0] band_cnt;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               band_cnt <= '0;
            end else if (band_end) begin
               band_cnt <= final_band ? '0 : band_cnt + 1'b1;
            end
         end
         assign final_band = (band_cnt == BAND_CW'(NUM_BANDS - 1));
      end
   endgenerate

   assign last_in_band = (pix_cnt == (final_band ? PIX_CW'(TAIL_PIX - 1)
                                                 : PIX_CW'(BAND_PIX - 1)));
   assign band_end     = pix_fin && last_in_band;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pix_cnt    <= '0;
         band_done  <= 1'b0;
         frame_done <= 1'b0;
      end else begin
         band_done  <= band_end;
         frame_done <= band_end && final_band;
         if (pix_fin) pix_cnt <= last_in_band ? '0 : pix_cnt + 1'b1;
      end
   end

   assert_band_pulse_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      band_done |=> !band_done)
      else $error("band_done wider than one clock");

   assert_pix_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pix_cnt < PIX_CW'(BAND_PIX))
      else $error("pixel counter beyond band size");

   assert_frame_with_band_R6: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> band_done)
      else $error("frame_done without band_done");

endmodule

// File: rtl/pin_select.sv
module pin_select
   import band_spi_pkg::*;
(
   input  logic      host_sel,
   input  spi_pins_t core_pins,
   input  spi_pins_t host_pins,
   output spi_pins_t disp_pins
);

   assign disp_pins = host_sel ? host_pins : core_pins;

endmodule

// File: rtl/band_spi_streamer.sv
module band_spi_streamer
   import band_spi_pkg::*;
#(
   parameter int SCREEN_W   = 240,
   parameter int SCREEN_H   = 320,
   parameter int BAND_LINES = 64,
   parameter int CLK_DIV    = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [PIX_BITS-1:0] s_tdata,
   input  logic                s_tvalid,
   output logic                s_tready,
   input  logic                host_sel,
   input  logic                host_sck,
   input  logic                host_mosi,
   input  logic                host_cs_n,
   input  logic                host_dc,
   output logic                disp_sck,
   output logic                disp_mosi,
   output logic                disp_cs_n,
   output logic                disp_dc,
   output logic                band_done,
   output logic                frame_done
);

   spi_pins_t core_pins;
   spi_pins_t host_pins;
   spi_pins_t disp_pins;
   logic      last_in_band;
   logic      pix_fin;

   assign host_pins = '{sck: host_sck, mosi: host_mosi, cs_n: host_cs_n, dc: host_dc};

   pixel_shifter #(
      .PIX_W   (PIX_BITS),
      .CLK_DIV (CLK_DIV)
   ) u_shifter (
      .clk          (clk),
      .rst_n        (rst_n),
      .en           (!host_sel),
      .in_data      (s_tdata),
      .in_valid     (s_tvalid),
      .in_ready     (s_tready),
      .last_in_band (last_in_band),
      .pix_fin      (pix_fin),
      .pins         (core_pins)
   );

   band_tracker #(
      .SCREEN_W   (SCREEN_W),
      .SCREEN_H   (SCREEN_H),
      .BAND_LINES (BAND_LINES)
   ) u_tracker (
      .clk          (clk),
      .rst_n        (rst_n),
      .pix_fin      (pix_fin),
      .last_in_band (last_in_band),
      .band_done    (band_done),
      .frame_done   (frame_done)
   );

   pin_select u_select (
      .host_sel  (host_sel),
      .core_pins (core_pins),
      .host_pins (host_pins),
      .disp_pins (disp_pins)
   );

   assign disp_sck  = disp_pins.sck;
   assign disp_mosi = disp_pins.mosi;
   assign disp_cs_n = disp_pins.cs_n;
   assign disp_dc   = disp_pins.dc;

   assert_cs_rise_with_band_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (band_done && !host_sel) |-> disp_cs_n)
      else $error("chip select low while band_done pulses");

endmodule

// File: tb/band_spi_streamer_tb.sv
module band_spi_streamer_tb;

   localparam int CLK_P   = 10;
   localparam int W       = 3;
   localparam int H       = 5;
   localparam int BAND    = 2;
   localparam int DIV     = 2;
   localparam int NB      = (H + BAND - 1) / BAND;
   localparam int FRAME_PIX = W * H;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] s_tdata = '0;
   logic        s_tvalid = 1'b0;
   logic        s_tready;
   logic        host_sel = 1'b0;
   logic        host_sck = 1'b0;
   logic        host_mosi = 1'b0;
   logic        host_cs_n = 1'b1;
   logic        host_dc = 1'b0;
   logic        disp_sck, disp_mosi, disp_cs_n, disp_dc;
   logic        band_done, frame_done;

   always #(CLK_P/2) clk = ~clk;

   band_spi_streamer #(
      .SCREEN_W (W), .SCREEN_H (H), .BAND_LINES (BAND), .CLK_DIV (DIV)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .s_tdata (s_tdata), .s_tvalid (s_tvalid), .s_tready (s_tready),
      .host_sel (host_sel), .host_sck (host_sck), .host_mosi (host_mosi),
      .host_cs_n (host_cs_n), .host_dc (host_dc),
      .disp_sck (disp_sck), .disp_mosi (disp_mosi), .disp_cs_n (disp_cs_n),
      .disp_dc (disp_dc), .band_done (band_done), .frame_done (frame_done)
   );

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_q[$];
   int hs_cnt = 0;
   int bits_rx = 0;
   int pix_rx = 0;
   logic [15:0] rx_sh = '0;
   int band_idx = 0;
   int band_start = 0;
   int bands_seen = 0;
   int frames_seen = 0;
   logic prev_sck = 1'b0;
   int run = 0;
   logic sel_in_run = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int band_size(input int b);
      return (b < NB - 1) ? W * BAND : W * (H - (NB - 1) * BAND);
   endfunction

   function automatic logic [15:0] pat(input int f, input int i);
      return 16'((i * 16'h1357) + (f * 16'hA5A5)) ^ 16'h8001;
   endfunction

   // serial receiver (R2, R3)
   always @(posedge disp_sck) begin
      if (rst_n && !host_sel) begin
         chk(disp_dc == 1'b1, "R3 dc high on data bit", int'(disp_dc), 1);
         rx_sh = {rx_sh[14:0], disp_mosi};
         bits_rx++;
         if (bits_rx % 16 == 0) begin
            chk(rx_sh == exp_q[pix_rx], "R2 pixel msb-first", int'(rx_sh), int'(exp_q[pix_rx]));
            pix_rx++;
         end
      end
   end

   // band, chip select and SCK phase monitor (R4, R5, R6, R8)
   always @(negedge clk) begin
      if (rst_n) begin
         if (band_done) begin
            bands_seen++;
            chk(pix_rx - band_start == band_size(band_idx), "R5 band pixel count",
                pix_rx - band_start, band_size(band_idx));
            chk(disp_cs_n == 1'b1, "R5 cs released with band_done", int'(disp_cs_n), 1);
            chk(frame_done == (band_idx == NB - 1), "R6 frame_done on last band",
                int'(frame_done), int'(band_idx == NB - 1));
            if (frame_done) frames_seen++;
            band_start = pix_rx;
            band_idx = (band_idx == NB - 1) ? 0 : band_idx + 1;
         end else begin
            if (frame_done) chk(1'b0, "R6 frame_done alone", 1, 0);
            if (!host_sel && pix_rx - band_start > 0 && pix_rx - band_start < band_size(band_idx))
               chk(disp_cs_n == 1'b0, "R4 cs low inside band", int'(disp_cs_n), 0);
         end
         if (host_sel) sel_in_run = 1'b1;
         if (disp_sck != prev_sck) begin
            if (!sel_in_run && !host_sel && (!disp_sck || (bits_rx % 16 != 1)))
               chk(run == DIV, "R8 sck phase length", run, DIV);
            run = 1;
            sel_in_run = host_sel;
         end else begin
            run++;
         end
         prev_sck = disp_sck;
      end
   end

   task automatic send_pixel(input logic [15:0] d);
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = d;
      while (!s_tready) @(negedge clk);
      chk(bits_rx == 16 * hs_cnt, "R7 accept only after 16 bits", bits_rx, 16 * hs_cnt);
      exp_q.push_back(d);
      hs_cnt++;
      @(negedge clk);
      s_tvalid = 1'b0;
      chk(s_tready == 1'b0, "R7 ready low while shifting", int'(s_tready), 0);
   endtask

   task automatic host_takeover();
      int bits_at;
      while (!(bits_rx == 16 * (hs_cnt - 1) + 5 && disp_sck == 1'b0)) @(negedge clk);
      host_sel = 1'b1;
      bits_at = bits_rx;
      s_tvalid = 1'b1;
      s_tdata  = 16'hDEAD;
      for (int k = 0; k < 16; k++) begin
         host_sck  = k[0];
         host_mosi = k[1];
         host_cs_n = k[2];
         host_dc   = k[3];
         @(negedge clk);
         chk({disp_sck, disp_mosi, disp_cs_n, disp_dc} == {k[0], k[1], k[2], k[3]},
             "R9 pins follow host", int'({disp_sck, disp_mosi, disp_cs_n, disp_dc}),
             int'({k[0], k[1], k[2], k[3]}));
         chk(s_tready == 1'b0, "R10 no ready under host", int'(s_tready), 0);
      end
      s_tvalid = 1'b0;
      host_sck = 1'b0;
      host_cs_n = 1'b1;
      @(negedge clk);
      chk(bits_rx == bits_at, "R10 no bits consumed under host", bits_rx, bits_at);
      host_sel = 1'b0;
   endtask

   initial begin
      #(CLK_P * 100000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(disp_cs_n == 1'b1, "R1 reset cs", int'(disp_cs_n), 1);
      chk(disp_sck == 1'b0, "R1 reset sck", int'(disp_sck), 0);
      chk(disp_mosi == 1'b0, "R1 reset mosi", int'(disp_mosi), 0);
      chk(s_tready == 1'b1, "R1 reset ready", int'(s_tready), 1);
      chk(band_done == 1'b0 && frame_done == 1'b0, "R1 reset pulses",
          int'({band_done, frame_done}), 0);

      // frame 0: back-to-back pixels
      for (int i = 0; i < FRAME_PIX; i++) send_pixel(pat(0, i));

      // frame 1: gaps between pixels, host takeover mid-pixel
      for (int i = 0; i < FRAME_PIX; i++) begin
         repeat (i % 4) @(negedge clk);
         send_pixel((i == 2) ? 16'hFFFF : (i == 7) ? 16'h0000 : pat(1, i));
         if (i == 4) host_takeover();
      end

      // frame 2: walking-one pixels
      for (int i = 0; i < FRAME_PIX; i++) send_pixel(16'(16'h0001 << i));

      while (pix_rx < 3 * FRAME_PIX) @(negedge clk);
      repeat (4 * DIV + 4) @(negedge clk);
      chk(bands_seen == 3 * NB, "R5 band pulses per three frames", bands_seen, 3 * NB);
      chk(frames_seen == 3, "R6 frame pulses", frames_seen, 3);
      chk(disp_cs_n == 1'b1, "R4 cs idle after frames", int'(disp_cs_n), 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule